// File: doc/BRIEF.md
# Programmable Periodic Event Divider

This block turns a 32.768 kHz enable tick into two kinds of one-cycle event: a periodic-interrupt event, used by a neighbouring register block to set its periodic and interrupt-request flags and to raise the interrupt line, and a square-wave event for a square-wave output stage. A 4-bit rate code selects how many ticks separate two events. A code of zero stops the divider.

Events are not counted from the moment the divider is switched on. A 16-bit counter advances on every tick, whether or not the divider is enabled. An event fires whenever the low bits of that counter, as selected by the rate code, wrap to zero. Because the schedule is a pure function of the counter and the present settings, a new code or enable takes effect on the very next tick and needs no restart. The register block drives the code and the two enables straight from its stored control bits. Flag clearing and bus access stay in that register block.

Top module: `periodic_rate_divider`

## Requirements
- R1: While rst_n is low and on the first cycle after it is released, per_pulse and sqw_pulse are 0. The free-running counter restarts from 0, so the first tick after reset brings the counter to 1.
- R2: With rate_code equal to 0, neither per_pulse nor sqw_pulse is ever asserted, whatever per_en and sqw_en are.
- R3: Rate codes 1 and 2 act as codes 8 and 9, which gives a period of 128 and 256 ticks.
- R4: For a rate code c from 3 to 15, the period is 2^(c-1) ticks (code 3 gives 4 ticks, code 15 gives 16384 ticks).
- R5: div_active is 1 exactly when rate_code is nonzero and at least one of per_en and sqw_en is 1. No event fires while div_active is 0.
- R6: The counter advances by one on every tick, even when the divider is idle. An event fires on the tick that brings the counter to a value that is a whole multiple of the period (modulo 65536), not a fixed number of ticks after enabling.
- R7: per_pulse fires only on events with per_en set. sqw_pulse fires only on events with sqw_en set. The two enables act independently, and when both are set the two pulses coincide.
- R8: Each pulse is one clock wide. It appears in the clock cycle right after the cycle in which tick_en was high.
- R9: A change of rate_code, per_en or sqw_en governs the very next tick, with no resynchronisation delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe at 32.768 kHz |
| rate_code | input | 4 | Period select; 0 stops the divider |
| per_en | input | 1 | Periodic-interrupt enable |
| sqw_en | input | 1 | Square-wave event enable |
| div_active | output | 1 | Divider is currently scheduling events |
| per_pulse | output | 1 | Periodic event: set periodic and interrupt flags |
| sqw_pulse | output | 1 | Square-wave event pulse |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a 4-bit code. This brings every rate code within reach, from the 4-tick period up to the 16384-tick period of code 15. The tick strobe comes every third clock. A behavioural model keeps an integer tick count and the period for each code, and it predicts both pulses and div_active on every clock. The bench changes the code and the enables in mid-period, so alignment to the free-running count is checked against a count-from-enable reading.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] rate_code_t;

  // Number of low counter bits that must wrap for an event.
  // Codes 1 and 2 alias onto 8 and 9; otherwise code-1.
  function automatic int unsigned wrap_bits(input rate_code_t code);
    int unsigned eff;
    if (code == 1)      eff = 8;
    else if (code == 2) eff = 9;
    else                eff = int'(code);
    return (eff == 0) ? 0 : eff - 1;
  endfunction
endpackage

// File: rtl/prd_free_counter.sv
module prd_free_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_o <= '0;
    else if (tick_en) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/prd_rate_decode.sv
module prd_rate_decode
  import prd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  rate_code_t       rate_code,
  input  logic             per_en,
  input  logic             sqw_en,
  output logic             active_o,
  output logic [CNT_W-1:0] mask_o
);
  int unsigned nbits;

  always_comb begin
    nbits    = wrap_bits(rate_code);
    active_o = (rate_code != '0) && (per_en || sqw_en);
  end

  // A counter bit takes part in the wrap test when it lies below nbits.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (nbits > i);
  end
endmodule

// File: rtl/prd_event_stage.sv
module prd_event_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] mask,
  input  logic             active,
  input  logic             per_en,
  input  logic             sqw_en,
  output logic             per_pulse_o,
  output logic             sqw_pulse_o
);
  logic [CNT_W-1:0] cnt_next;
  logic             hit;

  always_comb begin
    cnt_next = cnt + 1'b1;
    hit      = tick_en && active && ((cnt_next & mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_pulse_o <= 1'b0;
      sqw_pulse_o <= 1'b0;
    end else begin
      per_pulse_o <= hit && per_en;
      sqw_pulse_o <= hit && sqw_en;
    end
  end
endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
  import prd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              per_en,
  input  logic              sqw_en,
  output logic              div_active,
  output logic              per_pulse,
  output logic              sqw_pulse
);
  logic [CNT_W-1:0] free_cnt;
  logic [CNT_W-1:0] wrap_mask;

  prd_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_o   (free_cnt)
  );

  prd_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .rate_code (rate_code),
    .per_en    (per_en),
    .sqw_en    (sqw_en),
    .active_o  (div_active),
    .mask_o    (wrap_mask)
  );

  prd_event_stage #(.CNT_W(CNT_W)) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cnt         (free_cnt),
    .mask        (wrap_mask),
    .active      (div_active),
    .per_en      (per_en),
    .sqw_en      (sqw_en),
    .per_pulse_o (per_pulse),
    .sqw_pulse_o (sqw_pulse)
  );
endmodule

// File: rtl/prd_checker.sv
module prd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [3:0]       rate_code,
  input logic             per_en,
  input logic             sqw_en,
  input logic             per_pulse,
  input logic             sqw_pulse,
  input logic [CNT_W-1:0] free_cnt
);
  // R2
  code_zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate_code) == 4'd0) |-> (!per_pulse && !sqw_pulse));

  // R7
  per_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |-> $past(per_en));

  // R7
  sqw_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> $past(sqw_en));

  // R8
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_pulse || sqw_pulse) |-> $past(tick_en));

  // R8
  per_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> !per_pulse);

  // R6
  counter_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && $past(rst_n)) |=> $stable(free_cnt));
endmodule

bind periodic_rate_divider prd_checker #(.CNT_W(CNT_W)) u_prd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .rate_code (rate_code),
  .per_en    (per_en),
  .sqw_en    (sqw_en),
  .per_pulse (per_pulse),
  .sqw_pulse (sqw_pulse),
  .free_cnt  (free_cnt)
);

// File: tb/periodic_rate_divider_tb_top.sv
`timescale 1ns/1ps
module periodic_rate_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       div_active, per_pulse, sqw_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;

  int  ref_cnt = 0;
  bit  exp_per = 1'b0;
  bit  exp_sqw = 1'b0;

  always #10 clk = ~clk;

  periodic_rate_divider dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
    .per_en(per_en), .sqw_en(sqw_en), .div_active(div_active),
    .per_pulse(per_pulse), .sqw_pulse(sqw_pulse)
  );

  function automatic int period_of(input int code);
    if (code == 1) return 128;
    if (code == 2) return 256;
    return 1 << (code - 1);
  endfunction

  // Behavioural reference: integer tick count and period arithmetic.
  always @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt = 0; exp_per = 0; exp_sqw = 0;
    end else if (tick_en) begin
      bit fire;
      ref_cnt = (ref_cnt + 1) % 65536;
      fire = (rate_code != 0) && (per_en || sqw_en) &&
             ((ref_cnt % period_of(int'(rate_code))) == 0);
      exp_per = fire && per_en;
      exp_sqw = fire && sqw_en;
    end else begin
      exp_per = 0; exp_sqw = 0;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check(cur_req, "per_pulse", int'(per_pulse), int'(exp_per));
      check(cur_req, "sqw_pulse", int'(sqw_pulse), int'(exp_sqw));
      check("R5", "div_active", int'(div_active),
            int'((rate_code != 0) && (per_en || sqw_en)));
    end
  end

  // Tick generator: one strobe every third clock.
  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "per_pulse in reset", int'(per_pulse), 0);
    check("R1", "sqw_pulse in reset", int'(sqw_pulse), 0);
    @(negedge clk) rst_n = 1'b1;
    check("R1", "per_pulse after reset", int'(per_pulse), 0);
    model_on = 1'b1;

    // R4 + R7: fastest period, periodic only
    cur_req = "R4"; rate_code = 4'd3; per_en = 1'b1;
    run_ticks(40);
    // R7: square-wave only, code 6 (32 ticks)
    cur_req = "R7"; per_en = 1'b0; sqw_en = 1'b1; rate_code = 4'd6;
    run_ticks(100);
    // R3: aliased codes with both enables
    cur_req = "R3"; per_en = 1'b1; rate_code = 4'd1;
    run_ticks(300);
    rate_code = 4'd2;
    run_ticks(600);
    // R2: code 0 with both enables
    cur_req = "R2"; rate_code = 4'd0;
    run_ticks(200);
    // R5: nonzero code, no enable
    cur_req = "R5"; rate_code = 4'd3; per_en = 1'b0; sqw_en = 1'b0;
    run_ticks(37);
    // R6: enable mid-period; event at counter multiple, not after enable
    cur_req = "R6"; rate_code = 4'd5; per_en = 1'b1;
    run_ticks(45);
    // R9: code change in mid-period takes effect on the next tick
    cur_req = "R9"; rate_code = 4'd10;
    run_ticks(300);
    rate_code = 4'd4;
    run_ticks(21);
    sqw_en = 1'b1; per_en = 1'b0;
    run_ticks(19);
    // R4: slowest period, code 15
    cur_req = "R4"; rate_code = 4'd15; per_en = 1'b1;
    run_ticks(16500);
    // R8: single-cycle pulses already covered every clock; close out
    cur_req = "R8"; rate_code = 4'd3;
    run_ticks(20);
    model_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule